// File: doc/BRIEF.md
# Bit-band alias translator

This block sits between a bus master and a small byte-wide synchronous SRAM. It gives every bit of a 1 KB backing window its own 32-bit word in an alias region. A write to an alias word becomes an atomic read-modify-write of that single bit. A read of an alias word returns the bit as 0 or 1. Ordinary byte accesses to the backing window are forwarded to the RAM unchanged. Any other access receives an error response.

Firmware can therefore set, clear or test a flag with one store or one load. It does not need a load, mask and store sequence that an interrupt could split. The master raises `req_valid` with the address, direction, size and data. A request is taken on a clock edge where `req_ready` is high. Exactly one response comes back later on `resp_valid`.

Top module: `bitband_xlate`

## Requirements
- R1: Alias address 0x22000000 + off*32 + bit*4 selects bit `bit` (0..7) of backing byte `off` (0..1023), and `mem_addr` carries `off`. The alias region spans 0x22000000 to 0x22007FFF.
- R2: On an alias write, bit 0 of `req_wdata` is the new value of the target bit (1 sets, 0 clears). Write-data bits 31:1 have no effect.
- R3: An alias write leaves the other seven bits of the target byte unchanged.
- R4: An alias read responds with 0x00000001 when the target bit is set and 0x00000000 when it is clear.
- R5: Alias address bits 1:0 and the size field have no effect on an alias access.
- R6: For an accepted alias write, the byte is read in the acceptance cycle and written in the next cycle. `req_ready` is low during that write cycle, so no request is taken between the read and the write. The response comes two cycles after acceptance.
- R7: Backing-window accesses (0x20000000 to 0x200003FF) with byte size (`req_size` = 2'b00; 2'b01 is halfword, 2'b10 is word) go straight to the RAM. A write stores `req_wdata[7:0]`. A read responds with the byte zero-extended to 32 bits. Both respond one cycle after acceptance.
- R8: An address outside both windows, or a backing-window access whose size is not byte, responds one cycle later with `resp_err` = 1 and data 0. It makes no RAM access and changes no memory contents.
- R9: After reset `req_ready` is 1, and `resp_valid` and `mem_en` are 0 while no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_rdata | output | 32 | Read data, valid with resp_valid |
| resp_err | output | 1 | Access rejected |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 10 | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, valid the cycle after a read |

## Verification
The assertions check several rules on every cycle. Accepting an alias write must be followed by a stalled write cycle to the same byte. The byte written back may differ from the byte read in at most one bit. A rejected request must never enable the RAM. Every response must be zero in its upper 24 bits. The bench scenarios show the rest. They show the address arithmetic at the window edges, and that bit 0 of the write data alone decides the new bit value. They show that masked address bits and the size field leave an alias access unaffected. They also show that a request held on the bus during a read-modify-write observes the updated bit once it is accepted.

// File: rtl/bb_pkg.sv
package bb_pkg;

  // Classification of one bus request after address decode
  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_PASS_RD = 3'd1,
    K_PASS_WR = 3'd2,
    K_BIT_RD  = 3'd3,
    K_BIT_WR  = 3'd4,
    K_ERR     = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] bsel;   // bit index inside the backing byte
    logic       bval;   // new bit value for an alias write
  } op_t;

  localparam logic [1:0] SZ_BYTE = 2'b00;

endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bb_decode.sv
module bb_decode #(
  parameter int          OFS_W      = 10,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter logic [31:0] BACK_BASE  = 32'h2000_0000
) (
  input  logic             [31:0]      addr,
  input  logic                         we,
  input  logic             [1:0]       size,
  input  logic             [31:0]      wdata,
  output bb_pkg::op_t                  op,
  output logic             [OFS_W-1:0] ofs
);
  import bb_pkg::*;

  // one alias word per backing bit: 8 bits * 4 bytes = 32 bytes per backing byte
  localparam int SPAN_W = OFS_W + 5;

  logic alias_hit;
  logic back_hit;

  always_comb begin
    alias_hit = (addr[31:SPAN_W] == ALIAS_BASE[31:SPAN_W]);
    back_hit  = (addr[31:OFS_W]  == BACK_BASE[31:OFS_W]);
    op        = '0;
    op.kind   = K_ERR;
    ofs       = '0;
    if (alias_hit) begin
      ofs     = addr[SPAN_W-1:5];
      op.bsel = addr[4:2];
      op.bval = wdata[0];
      op.kind = we ? K_BIT_WR : K_BIT_RD;
    end else if (back_hit) begin
      ofs = addr[OFS_W-1:0];
      if (size == SZ_BYTE) begin
        op.kind = we ? K_PASS_WR : K_PASS_RD;
      end
    end
  end

endmodule

// File: rtl/bb_bitops.sv
module bb_bitops #(
  parameter int BYTE_W = 8,
  localparam int SEL_W = $clog2(BYTE_W)
) (
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [SEL_W-1:0]  bsel,
  input  logic              bval,
  output logic [BYTE_W-1:0] merged,
  output logic              picked
);

  for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
    assign merged[g] = (bsel == SEL_W'(g)) ? bval : old_byte[g];
  end

  assign picked = old_byte[bsel];

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl #(
  parameter int OFS_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  bb_pkg::op_t        op,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [7:0]         wbyte,
  input  logic [7:0]         merged,
  output logic               req_ready,
  output logic               mem_en,
  output logic               mem_we,
  output logic [OFS_W-1:0]   mem_addr,
  output logic [7:0]         mem_wdata,
  output logic               rsp_v,
  output bb_pkg::kind_e      rsp_kind,
  output logic [2:0]         hold_bsel,
  output logic               hold_bval
);
  import bb_pkg::*;

  typedef enum logic {ST_IDLE = 1'b0, ST_WRBACK = 1'b1} state_e;

  state_e             state_q, state_d;
  logic               rsp_v_q, rsp_v_d;
  kind_e              rsp_kind_q, rsp_kind_d;
  logic [OFS_W-1:0]   hold_ofs_q;
  logic [2:0]         hold_bsel_q;
  logic               hold_bval_q;
  logic               accept;
  logic               hold_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hold_en   = accept;

  // next-state and memory port
  always_comb begin
    state_d    = state_q;
    rsp_v_d    = 1'b0;
    rsp_kind_d = K_NONE;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = ofs;
    mem_wdata  = wbyte;
    if (state_q == ST_WRBACK) begin
      mem_en     = 1'b1;
      mem_we     = 1'b1;
      mem_addr   = hold_ofs_q;
      mem_wdata  = merged;
      rsp_v_d    = 1'b1;
      rsp_kind_d = K_BIT_WR;
      state_d    = ST_IDLE;
    end else if (accept) begin
      unique case (op.kind)
        K_PASS_RD, K_BIT_RD: begin
          mem_en     = 1'b1;
          rsp_v_d    = 1'b1;
          rsp_kind_d = op.kind;
        end
        K_PASS_WR: begin
          mem_en     = 1'b1;
          mem_we     = 1'b1;
          rsp_v_d    = 1'b1;
          rsp_kind_d = K_PASS_WR;
        end
        K_BIT_WR: begin
          mem_en  = 1'b1;
          state_d = ST_WRBACK;
        end
        default: begin
          rsp_v_d    = 1'b1;
          rsp_kind_d = K_ERR;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rsp_v_q    <= 1'b0;
      rsp_kind_q <= K_NONE;
    end else begin
      state_q    <= state_d;
      rsp_v_q    <= rsp_v_d;
      rsp_kind_q <= rsp_kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ofs_q  <= '0;
      hold_bsel_q <= '0;
      hold_bval_q <= 1'b0;
    end else if (hold_en) begin
      hold_ofs_q  <= ofs;
      hold_bsel_q <= op.bsel;
      hold_bval_q <= op.bval;
    end
  end

  assign rsp_v     = rsp_v_q;
  assign rsp_kind  = rsp_kind_q;
  assign hold_bsel = hold_bsel_q;
  assign hold_bval = hold_bval_q;

  // R6
  rmw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op.kind == K_BIT_WR) |=>
      (!req_ready && mem_en && mem_we && mem_addr == $past(ofs)));

  // R6
  rmw_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op.kind == K_BIT_WR) |=> (!rsp_v ##1 rsp_v));

  // R8
  err_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op.kind == K_ERR) |-> !mem_en);

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate #(
  parameter int          OFS_W      = 10,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter logic [31:0] BACK_BASE  = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              resp_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [OFS_W-1:0]  mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  import bb_pkg::*;

  logic             rst_sync_n;
  op_t              dec_op;
  logic [OFS_W-1:0] dec_ofs;
  logic [7:0]       merged;
  logic             picked;
  logic             rsp_v;
  kind_e            rsp_kind;
  logic [2:0]       hold_bsel;
  logic             hold_bval;

  bb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bb_decode #(
    .OFS_W      (OFS_W),
    .ALIAS_BASE (ALIAS_BASE),
    .BACK_BASE  (BACK_BASE)
  ) u_dec (
    .addr  (req_addr),
    .we    (req_we),
    .size  (req_size),
    .wdata (req_wdata),
    .op    (dec_op),
    .ofs   (dec_ofs)
  );

  bb_bitops #(.BYTE_W(8)) u_bits (
    .old_byte (mem_rdata),
    .bsel     (hold_bsel),
    .bval     (hold_bval),
    .merged   (merged),
    .picked   (picked)
  );

  bb_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .op        (dec_op),
    .ofs       (dec_ofs),
    .wbyte     (req_wdata[7:0]),
    .merged    (merged),
    .req_ready (req_ready),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rsp_v     (rsp_v),
    .rsp_kind  (rsp_kind),
    .hold_bsel (hold_bsel),
    .hold_bval (hold_bval)
  );

  // response formatting
  always_comb begin
    resp_valid = rsp_v;
    resp_err   = rsp_v && (rsp_kind == K_ERR);
    resp_rdata = '0;
    if (rsp_v) begin
      unique case (rsp_kind)
        K_PASS_RD: resp_rdata = {24'h0, mem_rdata};
        K_BIT_RD:  resp_rdata = {31'h0, picked};
        default:   resp_rdata = '0;
      endcase
    end
  end

  // R3
  one_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_we && !req_ready) |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

  // R4
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_valid |-> (resp_rdata[31:8] == 24'h0));

  // R8
  err_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_err |-> (resp_valid && resp_rdata == 32'h0));

endmodule

// File: tb/bitband_xlate_test.sv
module bitband_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        req_we;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        resp_err;
  logic        mem_en;
  logic        mem_we;
  logic [9:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  bitband_xlate uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .req_we (req_we), .req_size (req_size), .req_wdata (req_wdata),
    .resp_valid (resp_valid), .resp_rdata (resp_rdata), .resp_err (resp_err),
    .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
  );

  // byte-wide synchronous RAM model
  logic [7:0] ram [0:1023];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
  end

  typedef struct packed {
    logic        we;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        err;
    logic [31:0] rdata;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 2'd0, 32'h2000_0005, 32'h0000_00A5, 1'b0, 32'h0,  8'd7}, // R7 write byte 5
    '{1'b0, 2'd0, 32'h2000_0005, 32'h0,         1'b0, 32'hA5, 8'd7}, // R7 read back
    '{1'b0, 2'd2, 32'h2200_00A0, 32'h0,         1'b0, 32'h1,  8'd4}, // R4 bit0 of 0xA5
    '{1'b0, 2'd2, 32'h2200_00A4, 32'h0,         1'b0, 32'h0,  8'd4}, // R4 bit1 of 0xA5
    '{1'b1, 2'd2, 32'h2200_00A4, 32'hFFFF_FFFF, 1'b0, 32'h0,  8'd2}, // R2 set bit1
    '{1'b0, 2'd0, 32'h2000_0005, 32'h0,         1'b0, 32'hA7, 8'd3}, // R3 byte 0xA7
    '{1'b1, 2'd2, 32'h2200_00BC, 32'hFFFF_FFFE, 1'b0, 32'h0,  8'd2}, // R2 clear bit7
    '{1'b0, 2'd0, 32'h2000_0005, 32'h0,         1'b0, 32'h27, 8'd3}, // R3 byte 0x27
    '{1'b0, 2'd2, 32'h2200_00B7, 32'h0,         1'b0, 32'h1,  8'd5}, // R5 low bits set
    '{1'b1, 2'd0, 32'h2000_03FF, 32'h0000_0080, 1'b0, 32'h0,  8'd7}, // R7 last byte
    '{1'b0, 2'd2, 32'h2200_7FFC, 32'h0,         1'b0, 32'h1,  8'd1}, // R1 top alias word
    '{1'b1, 2'd1, 32'h2200_7FEC, 32'h0000_0003, 1'b0, 32'h0,  8'd1}, // R1 bit3 of 0x3FF
    '{1'b0, 2'd0, 32'h2000_03FF, 32'h0,         1'b0, 32'h88, 8'd1}, // R1 byte 0x88
    '{1'b1, 2'd0, 32'h2200_0000, 32'h0000_0001, 1'b0, 32'h0,  8'd5}, // R5 byte size alias
    '{1'b0, 2'd0, 32'h2000_0000, 32'h0,         1'b0, 32'h1,  8'd1}, // R1 base mapping
    '{1'b0, 2'd2, 32'h3000_0000, 32'h0,         1'b1, 32'h0,  8'd8}, // R8 unmapped
    '{1'b1, 2'd2, 32'h2000_0004, 32'hDEAD_BEEF, 1'b1, 32'h0,  8'd8}, // R8 word passthrough
    '{1'b0, 2'd0, 32'h2000_0004, 32'h0,         1'b0, 32'h0,  8'd8}, // R8 memory untouched
    '{1'b0, 2'd2, 32'h2200_8000, 32'h0,         1'b1, 32'h0,  8'd8}, // R8 past alias end
    '{1'b1, 2'd0, 32'h2000_0400, 32'h0000_0055, 1'b1, 32'h0,  8'd8}  // R8 past backing end
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic txn(input logic we, input logic [1:0] size, input logic [31:0] addr,
                     input logic [31:0] wdata, input logic exp_err,
                     input logic [31:0] exp_rd, input int rq);
    bit saw_mem;
    bit is_bitwr;
    is_bitwr = we && !exp_err && (addr[31:15] == 17'h4400);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = size;
    req_addr = addr; req_wdata = wdata;
    #1;
    saw_mem = mem_en;
    chk(req_ready == 1'b1, rq, "ready at offer", {31'h0, req_ready}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (is_bitwr) begin
      // R6 write-back cycle: stalled, writing, no response yet
      chk(!req_ready && mem_we && !resp_valid, 6, "rmw write cycle",
          {29'h0, req_ready, mem_we, resp_valid}, 32'h2);
      @(negedge clk);
    end
    chk(resp_valid == 1'b1, rq, "resp_valid", {31'h0, resp_valid}, 32'h1);
    chk(resp_err == exp_err, rq, "resp_err", {31'h0, resp_err}, {31'h0, exp_err});
    chk(resp_rdata == exp_rd, rq, "resp_rdata", resp_rdata, exp_rd);
    if (exp_err) chk(!saw_mem, 8, "no ram access on error", {31'h0, saw_mem}, 32'h0);
  endtask

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
    mem_rdata = 8'h00;
    req_valid = 1'b0; req_we = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, 9, "ready after reset", {31'h0, req_ready}, 32'h1);
    chk(resp_valid == 1'b0, 9, "resp_valid after reset", {31'h0, resp_valid}, 32'h0);
    chk(mem_en == 1'b0, 9, "mem_en after reset", {31'h0, mem_en}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      txn(VEC[v].we, VEC[v].size, VEC[v].addr, VEC[v].wdata,
          VEC[v].err, VEC[v].rdata, int'(VEC[v].rq));
    end

    // R6 back-to-back: alias write clearing bit0 of byte 0, then a read held on the bus
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_size = 2'd2;
    req_addr = 32'h2200_0000; req_wdata = 32'h0;
    @(posedge clk);
    @(negedge clk);
    req_we = 1'b0; req_addr = 32'h2200_0000;
    chk(req_ready == 1'b0, 6, "held request stalled", {31'h0, req_ready}, 32'h0);
    chk(mem_addr == 10'd0 && mem_wdata == 8'h00, 6, "write-back byte",
        {14'h0, mem_addr, mem_wdata}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk(resp_valid && !resp_err, 6, "write response", {30'h0, resp_valid, resp_err}, 32'h2);
    chk(req_ready == 1'b1, 6, "ready after write-back", {31'h0, req_ready}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid && resp_rdata == 32'h0, 6, "held read sees new bit",
        resp_rdata, 32'h0);

    // R3 neighbour bits of byte 5 after two bit writes
    txn(1'b0, 2'd0, 32'h2000_0005, 32'h0, 1'b0, 32'h27, 3);

    @(negedge clk);
    chk(mem_en == 1'b0 && resp_valid == 1'b0, 9, "idle bus quiet",
        {30'h0, mem_en, resp_valid}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule